// File: doc/BRIEF.md
# Dual Feedback-Gated PWM Converter Drive

This block produces pulse-width drive signals for external DC-to-DC converters. Each channel output repeats at a fixed rate (96 kHz by default) derived from the system clock, and each period is cut into sixteen equal slots. A channel's 4-bit duty setting picks how many leading slots of the period are active. The usable range runs from one to fifteen slots, so a channel can never sit fully on or fully off while it is running.

Each channel has a feedback input, normally driven by a comparator that watches the converter output. When the feedback is low, pulses are held back. Feedback is synchronised and sampled only where one period ends and the next begins. Duty, enable and output sense are sampled at the same point, so a whole period is produced from one consistent setting and no shortened pulse can appear. Output sense is selectable per channel. The resting level of an idle channel follows the selected sense.

Top module: `conv_pwm_drive`

## Requirements
- R1: One period is sixteen slots of PRESCALE = CLK_HZ/(RATE_HZ*16) system clock cycles each. Counting starts at reset release, so period boundaries fall after every multiple of 16*PRESCALE rising edges (192 with the default parameters).
- R2: In slot s (0 to 15) of a running period, the output is at its active level exactly when s is less than the effective duty.
- R3: A programmed duty of 0 behaves as 1, giving one active slot per period.
- R4: A programmed duty of 15 gives fifteen active slots. Slot 15 is always at the inactive level.
- R5: With ch_invert bit = 0 the active level is high. With ch_invert bit = 1 it is low. The inactive level of a channel always equals its ch_invert bit.
- R6: A channel whose fb_ok bit, after a two-flop synchroniser, is low at a period boundary produces no pulses for that whole period. High feedback lets pulses through. Feedback must be steady for at least two cycles before the boundary.
- R7: A channel whose ch_en bit is low at a period boundary rests at its inactive level for that whole period.
- R8: Changes of duty, sense, enable or feedback in the middle of a period leave the current period unchanged. They take effect from the next boundary.
- R9: During reset and throughout the first period after reset, all outputs are low.
- R10: Channels are independent. Channel k uses only ch_en[k], ch_invert[k], ch_duty[4k+3:4k] and fb_ok[k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NUM_CH | Per-channel run enable |
| ch_duty | input | 4*NUM_CH | Per-channel duty in sixteenths, channel k in bits 4k+3:4k |
| ch_invert | input | NUM_CH | Per-channel sense: 0 active high, 1 active low |
| fb_ok | input | NUM_CH | Asynchronous comparator feedback, high permits pulses |
| drv_out | output | NUM_CH | Converter drive outputs |

## Verification
A slot counter that steps wrongly moves the active-to-inactive edge by at least PRESCALE cycles, and a bad prescaler stretches every slot. Either fault shows within one period (192 cycles), because every cycle of a checked period is compared. A latch that updates mid-period, or a broken feedback gate, changes the level inside the period where the stimulus moves. A clamp fault shows as a missing first pulse or an active final slot in the first period that uses that setting.

// File: rtl/conv_pwm_pkg.sv
package conv_pwm_pkg;
   localparam int SLOT_W = 4;
   localparam int SLOTS  = 1 << SLOT_W;

   typedef struct packed {
      logic              en;
      logic              inv;
      logic [SLOT_W-1:0] duty;
   } pwm_cfg_t;
endpackage

// File: rtl/conv_pwm_sync.sv
module conv_pwm_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/conv_pwm_timebase.sv
module conv_pwm_timebase
   import conv_pwm_pkg::*;
#(
   parameter int PRESCALE = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [SLOT_W-1:0] slot,
   output logic              boundary
);
   logic slot_tick;

   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign slot_tick = 1'b1;
      end else begin : g_div
         localparam int CNT_W = $clog2(PRESCALE);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
         logic [CNT_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                   pre_q <= pre_q + 1'b1;
         end

         assign slot_tick = (pre_q == LAST);

         p_pre_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot <= '0;
      else if (slot_tick) slot <= slot + 1'b1;
   end

   assign boundary = slot_tick && (slot == SLOT_W'(SLOTS - 1));

   p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |=> slot == $past(slot) + SLOT_W'(1));
   p_slot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> $stable(slot));
   p_bnd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> slot == '0);
endmodule

// File: rtl/conv_pwm_channel.sv
module conv_pwm_channel
   import conv_pwm_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic [SLOT_W-1:0] slot,
   input  pwm_cfg_t          cfg,
   input  logic              fb_s,
   output logic              drv
);
   localparam logic [SLOT_W-1:0] DUTY_MIN = SLOT_W'(1);
   localparam logic [SLOT_W-1:0] DUTY_MAX = SLOT_W'(SLOTS - 1);

   function automatic logic [SLOT_W-1:0] clamp_duty(input logic [SLOT_W-1:0] d);
      if (d < DUTY_MIN) return DUTY_MIN;
      if (d > DUTY_MAX) return DUTY_MAX;
      return d;
   endfunction

   logic              run_q;
   logic              inv_q;
   logic [SLOT_W-1:0] duty_q;
   logic              lvl_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         inv_q  <= 1'b0;
         duty_q <= DUTY_MIN;
      end else if (boundary) begin
         run_q  <= cfg.en && fb_s;
         inv_q  <= cfg.inv;
         duty_q <= clamp_duty(cfg.duty);
      end
   end

   assign lvl_c = (run_q && (slot < duty_q)) ^ inv_q;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drv <= 1'b0;
            else        drv <= lvl_c;
         end
      end else begin : g_comb
         assign drv = lvl_c;
      end
   endgenerate

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable({run_q, inv_q, duty_q}));
   p_first_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && slot == '0) |-> lvl_c != inv_q);
   p_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == DUTY_MAX + SLOT_W'(0) && slot == SLOT_W'(SLOTS - 1)) |-> lvl_c == inv_q);
   p_rest_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> lvl_c == inv_q);
endmodule

// File: rtl/conv_pwm_drive.sv
module conv_pwm_drive
   import conv_pwm_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int CLK_HZ      = 18_432_000,
   parameter int RATE_HZ     = 96_000,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [NUM_CH*SLOT_W-1:0] ch_duty,
   input  logic [NUM_CH-1:0]        ch_invert,
   input  logic [NUM_CH-1:0]        fb_ok,
   output logic [NUM_CH-1:0]        drv_out
);
   localparam int SLOT_HZ  = RATE_HZ * SLOTS;
   localparam int PRESCALE = CLK_HZ / SLOT_HZ;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("conv_pwm_drive: NUM_CH must be at least 1");
      end
      if (PRESCALE < 1 || (CLK_HZ % SLOT_HZ) != 0) begin : g_bad_clk
         $error("conv_pwm_drive: CLK_HZ must be a whole multiple of 16*RATE_HZ");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("conv_pwm_drive: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic              boundary;
   logic [NUM_CH-1:0] fb_s;

   conv_pwm_timebase #(.PRESCALE(PRESCALE)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot),
      .boundary (boundary)
   );

   conv_pwm_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_fb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fb_ok),
      .q     (fb_s)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         pwm_cfg_t cfg;
         assign cfg.en   = ch_en[g];
         assign cfg.inv  = ch_invert[g];
         assign cfg.duty = ch_duty[g*SLOT_W +: SLOT_W];

         conv_pwm_channel #(.OUT_REG(OUT_REG)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .boundary (boundary),
            .slot     (slot),
            .cfg      (cfg),
            .fb_s     (fb_s[g]),
            .drv      (drv_out[g])
         );
      end
   endgenerate

   p_sense_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!boundary && slot != '0) |=> $stable(drv_out) || $past(slot) != slot);
endmodule

// File: tb/conv_pwm_drive_bench.sv
module conv_pwm_drive_bench;
   localparam int NCH    = 2;
   localparam int PRE    = 12;
   localparam int SLOTS  = 16;
   localparam int PERIOD = PRE * SLOTS;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n;
   logic [NCH-1:0]   ch_en, ch_invert, fb_ok, drv_out;
   logic [NCH*4-1:0] ch_duty;
   int unsigned      cyc;
   int               checks = 0;
   int               errors = 0;
   int unsigned      wd = 0;

   conv_pwm_drive u_conv_pwm_drive (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_duty(ch_duty),
      .ch_invert(ch_invert), .fb_ok(fb_ok), .drv_out(drv_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // expected level from R2..R7
   function automatic logic exp_lvl(logic en, logic fb, logic inv, logic [3:0] d, int slot);
      int dd;
      dd = (d == 0) ? 1 : ((d >= SLOTS - 1) ? SLOTS - 1 : int'(d));
      return ((en && fb && slot < dd) ? 1'b1 : 1'b0) ^ inv;
   endfunction

   task automatic randomize_cfg();
      for (int c = 0; c < NCH; c++) begin
         ch_en[c]           = ($urandom % 5) != 0;
         fb_ok[c]           = ($urandom % 4) != 0;
         ch_invert[c]       = $urandom % 2;
         ch_duty[c*4 +: 4]  = 4'($urandom % 16);
      end
   endtask

   // check one whole period against the setting present at its boundary (R1, R8)
   task automatic check_period(string req, bit mid_flip);
      logic [NCH-1:0] e_c, f_c, i_c;
      logic [NCH*4-1:0] d_c;
      int bad [NCH];
      int bad_j [NCH];
      logic bad_a [NCH];
      logic bad_e [NCH];
      repeat (3) @(negedge clk);
      while ((cyc % PERIOD) != 0) @(negedge clk);
      e_c = ch_en; f_c = fb_ok; i_c = ch_invert; d_c = ch_duty;
      for (int c = 0; c < NCH; c++) begin bad[c] = 0; bad_j[c] = 0; bad_a[c] = 0; bad_e[c] = 0; end
      for (int j = 0; j < PERIOD; j++) begin
         if (j > 0) @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            logic e;
            e = exp_lvl(e_c[c], f_c[c], i_c[c], d_c[c*4 +: 4], j / PRE);
            if (drv_out[c] !== e) begin
               if (bad[c] == 0) begin bad_j[c] = j; bad_a[c] = drv_out[c]; bad_e[c] = e; end
               bad[c]++;
            end
         end
         if (mid_flip && j == PERIOD / 2) randomize_cfg();
      end
      for (int c = 0; c < NCH; c++) begin
         checks++;
         if (bad[c] != 0) begin
            errors++;
            $display("FAIL %s ch%0d cycle %0d of period: actual %b expected %b (%0d bad cycles)",
                     req, c, bad_j[c], bad_a[c], bad_e[c], bad[c]);
         end
      end
   endtask

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   initial begin
      int bad0;
      void'($urandom(32'd1729));
      rst_n = 1'b0;
      ch_en = '1; fb_ok = '1; ch_invert = '0; ch_duty = {4'd8, 4'd8};
      repeat (5) @(negedge clk);
      checks++;
      if (drv_out !== '0) begin
         errors++;
         $display("FAIL R9 in reset: actual %b expected 00", drv_out);
      end
      rst_n = 1'b1;
      // R9: first period after reset stays low
      bad0 = 0;
      for (int j = 0; j < PERIOD; j++) begin
         if (j > 0) @(negedge clk);
         if (drv_out !== '0) bad0++;
      end
      checks++;
      if (bad0 != 0) begin
         errors++;
         $display("FAIL R9 first period: actual %0d high cycles expected 0", bad0);
      end

      check_period("R1/R2 half duty", 1'b0);
      // R3 / R4 clamps, R10 different settings per channel
      ch_duty = {4'd15, 4'd0};
      check_period("R3/R4/R10 clamps", 1'b0);
      ch_duty = {4'd1, 4'd14};
      check_period("R2/R10 duty 14 and 1", 1'b0);
      // R5 sense
      ch_invert = 2'b01; ch_duty = {4'd5, 4'd11};
      check_period("R5 active low", 1'b0);
      // R6 feedback gating, R7 enable
      fb_ok = 2'b10; ch_en = 2'b11;
      check_period("R6 feedback low", 1'b0);
      fb_ok = 2'b11; ch_en = 2'b01; ch_invert = 2'b10;
      check_period("R7 disabled rest level", 1'b0);
      ch_en = 2'b11; ch_invert = 2'b00;
      check_period("R6 feedback restored", 1'b0);
      // R8 mid-period changes
      check_period("R8 mid-period change", 1'b1);
      check_period("R8 change applied", 1'b0);

      for (int k = 0; k < 30; k++) begin
         randomize_cfg();
         check_period("R2/R5/R6/R7 random", (k % 3) == 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule